// File: doc/BRIEF.md
# Frame-Replay Delayed Buffer Emulator

This block stands in for a packet buffer of capacity B whose service order is chosen by an outside policy. Arrivals (a valid strobe and a tag) are held in a small register store. On every slot the external policy may name one held tag to release. The block does not choose what leaves. It removes the named packet and writes the decision into a frame record at the current offset of the current frame. Each frame is B slots long. The recorded frame is played back a fixed number of frames later. The output stream is therefore the policy's departure stream shifted by a constant D = DLY_FRAMES × B slots, with the same order and the same gaps.

The record is a ring of DLY_FRAMES frames. The slot being replayed is read from the same position that the current slot then overwrites. Because of this, the policy can be FIFO, LIFO, priority or random, and the block needs no knowledge of which one it is. An arrival that finds all B entries occupied is dropped, and `overflow` is raised during that slot.

Top module: `frame_replay_buf`

## Requirements
- R1: The delay is D = DLY_FRAMES × B slots, with DLY_FRAMES ≥ 2. Slots are grouped into frames of B slots. A departure decision taken in slot t appears on the output in slot t+D exactly.
- R2: A departure that names a held tag is recorded with that tag. Exactly one stored copy of the tag is removed.
- R3: A slot with no departure produces an idle output slot (out_valid low, out_tag zero) D slots later. Gaps and order are therefore preserved.
- R4: A departure that names a tag not held yields an idle output D slots later and changes no stored entry.
- R5: An arrival in a slot that starts with all B entries occupied is dropped and `overflow` is high in that same slot. A later departure naming the dropped tag yields an idle output.
- R6: A departure is matched only against entries held at the start of its slot. A same-slot arrival cannot be matched, and a same-slot departure does not make room for a same-slot arrival.
- R7: While reset is asserted, out_valid and overflow (with no arrival) are low and the store is empty. After reset, the output stays idle for the first D slots.
- R8: The replayed stream matches the reference for any service policy, including FIFO, LIFO and random selection.
- R9: An accepted arrival occupies one entry. An entry freed by a departure can accept an arrival from the next slot on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Packet arrives this slot |
| arr_tag | input | TAG_W | Tag of the arriving packet |
| dep_valid | input | 1 | Reference policy releases a packet this slot |
| dep_tag | input | TAG_W | Tag the policy releases |
| out_valid | output | 1 | Replayed departure present this slot |
| out_tag | output | TAG_W | Replayed tag, zero when idle |
| overflow | output | 1 | Arrival this slot dropped because the store is full |

## Verification
The bench looks for these faults:
- An off-by-one in the replay position. Such a design emits every packet one slot early or late, so all replays shift.
- A full test taken after the same-slot departure. This design accepts an arrival that should drop, and its overflow strobe goes missing.
- A departure search that also sees the same-slot arrival. This design replays a packet that should leave an idle slot.
- A tag miss that is recorded as valid. This design outputs phantom packets, either from missing tags or during the warm-up window after reset.
- Control logic that only works for one service order. FIFO, LIFO and random policies each compare the output stream slot by slot against a shifted copy of the reference, so this fault shows up under at least one of them.

// File: rtl/frame_replay_buf.sv
module frame_replay_buf #(
  parameter int B          = 8,
  parameter int TAG_W      = 8,
  parameter int DLY_FRAMES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arr_valid,
  input  logic [TAG_W-1:0] arr_tag,
  input  logic             dep_valid,
  input  logic [TAG_W-1:0] dep_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             overflow
);
  localparam int D     = DLY_FRAMES * B;
  localparam int IDX_W = (B > 1) ? $clog2(B) : 1;
  localparam int OFF_W = IDX_W;
  localparam int FR_W  = (DLY_FRAMES > 1) ? $clog2(DLY_FRAMES) : 1;
  localparam int DA_W  = $clog2(D);

  logic [B-1:0]     occ;
  logic [TAG_W-1:0] held [B];
  logic [D-1:0]     rec_v;
  logic [TAG_W-1:0] rec_t [D];
  logic [OFF_W-1:0] off;
  logic [FR_W-1:0]  fr;
  logic             primed;

  logic             hit, full;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic [DA_W-1:0]  addr;

  assign full     = &occ;
  assign overflow = arr_valid & full;
  assign addr     = DA_W'(fr) * DA_W'(B) + DA_W'(off);
  assign out_valid = rec_v[addr];
  assign out_tag   = rec_v[addr] ? rec_t[addr] : '0;

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = B - 1; i >= 0; i--) begin
      if (occ[i] && held[i] == dep_tag) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!occ[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off    <= '0;
      fr     <= '0;
      primed <= 1'b0;
    end else begin
      if (addr == DA_W'(D - 1)) primed <= 1'b1;
      if (off == OFF_W'(B - 1)) begin
        off <= '0;
        fr  <= (fr == FR_W'(DLY_FRAMES - 1)) ? '0 : fr + 1'b1;
      end else begin
        off <= off + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
    end else begin
      if (dep_valid && hit) occ[hit_idx] <= 1'b0;
      if (arr_valid && !full) begin
        occ[free_idx]  <= 1'b1;
        held[free_idx] <= arr_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_v <= '0;
    end else begin
      rec_v[addr] <= dep_valid & hit;
      rec_t[addr] <= dep_tag;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (off == OFF_W'(B - 1)) |=> (off == '0)); // R1

  AST_IDLE_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !out_valid); // R7

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && full && !(dep_valid && hit)) |=>
      ($countones(occ) == $past($countones(occ)))); // R5

  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !full && !(dep_valid && hit)) |=>
      ($countones(occ) == $past($countones(occ)) + 1)); // R9

  AST_RELEASE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_valid && hit && !arr_valid) |=>
      ($countones(occ) + 1 == $past($countones(occ)))); // R2

  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_valid && !hit && !arr_valid) |=> $stable(occ)); // R4
endmodule

// File: tb/frame_replay_buf_tb.sv
module frame_replay_buf_tb_top;
  localparam int B = 8, TAG_W = 8, NF = 2, D = B * NF, N = 4000;

  logic clk = 0, rst_n = 0;
  logic arr_valid = 0, dep_valid = 0;
  logic [TAG_W-1:0] arr_tag = '0, dep_tag = '0;
  logic out_valid, overflow;
  logic [TAG_W-1:0] out_tag;

  frame_replay_buf #(.B(B), .TAG_W(TAG_W), .DLY_FRAMES(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_tag(arr_tag),
    .dep_valid(dep_valid), .dep_tag(dep_tag), .out_valid(out_valid),
    .out_tag(out_tag), .overflow(overflow));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, t = 0;
  bit done = 0;
  logic [7:0] q[$];
  bit   exp_v [N];
  logic [7:0] exp_t [N];
  string exp_l [N];
  logic [7:0] ctr = 8'h20;

  task automatic chk(bit ok, string lbl, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s slot %0d %s: actual %0h expected %0h", lbl, t, what, act, exp);
    end
  endtask

  function automatic int find(logic [7:0] tg);
    for (int i = 0; i < q.size(); i++) if (q[i] == tg) return i;
    return -1;
  endfunction

  task automatic slot(bit av, logic [7:0] at, bit dv, logic [7:0] dt, string lo, string ld);
    bit full_e, ev, xv;
    int h;
    logic [7:0] xt;
    string xl;
    arr_valid = av; arr_tag = at; dep_valid = dv; dep_tag = dt;
    #1;
    full_e = (q.size() == B);
    chk(overflow == (av && full_e), lo, "overflow", overflow, av && full_e);
    if (t < D) begin xv = 0; xt = 0; xl = "R7"; end
    else begin xv = exp_v[t-D]; xt = exp_v[t-D] ? exp_t[t-D] : 8'h0; xl = exp_l[t-D]; end
    chk(out_valid == xv, xl, "out_valid", out_valid, xv);
    chk(out_tag == xt, xl, "out_tag", out_tag, xt);
    h = dv ? find(dt) : -1;
    ev = (h >= 0);
    if (ev) q.delete(h);
    exp_v[t] = ev; exp_t[t] = dt;
    exp_l[t] = ev ? {"R1 R2 ", ld} : (dv ? ld : "R3");
    if (av && !full_e) q.push_back(at);
    t++;
    @(negedge clk);
  endtask

  task automatic run_phase(int mode, int n, string tagname);
    for (int k = 0; k < n; k++) begin
      bit av, dv;
      logic [7:0] at, dt;
      int r, idx;
      string ld;
      av = ($urandom % 3) != 0; at = ctr; ctr++;
      dv = 0; dt = 0; ld = tagname;
      r = $urandom % 8;
      if (q.size() > 0 && r < 5) begin
        idx = (mode == 0) ? 0 : (mode == 1) ? q.size() - 1 : int'($urandom % q.size());
        dv = 1; dt = q[idx];
      end else if (r == 5) begin
        dt = ctr + 8'd77;
        dv = (find(dt) < 0);
        ld = "R4";
      end
      slot(av, at, dv, dt, "R5", ld);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0, "R7", "out_valid in reset", out_valid, 0);
    chk(overflow == 0, "R7", "overflow in reset", overflow, 0);
    @(negedge clk);
    rst_n = 1;
    slot(1, 8'h10, 1, 8'h10, "R7", "R6");
    slot(0, 0, 1, 8'h10, "R7", "R2");
    slot(0, 0, 1, 8'h99, "R7", "R4");
    for (int i = 0; i < B; i++) slot(1, 8'h40 + 8'(i), 0, 0, "R9", "R3");
    slot(1, 8'h55, 0, 0, "R5", "R3");
    slot(0, 0, 1, 8'h55, "R5", "R5");
    slot(1, 8'h66, 1, 8'h43, "R6", "R6");
    slot(1, 8'h67, 0, 0, "R9", "R3");
    slot(0, 0, 1, 8'h67, "R9", "R9");
    slot(0, 0, 1, 8'h47, "R5", "R8");
    slot(0, 0, 1, 8'h40, "R5", "R8");
    run_phase(0, 600, "R8 fifo");
    run_phase(1, 600, "R8 lifo");
    run_phase(2, 600, "R8 random");
    for (int i = 0; i < D + 2; i++) slot(0, 0, 0, 0, "R5", "R3");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule